// File: doc/BRIEF.md
# Posted-CAS Command Latency Pipeline

This block reproduces the command-to-data timing of a double-data-rate memory device that accepts column commands early. On every rising clock edge it samples four active-low control pins and decodes row activation, column read and column write. A column command is first parked in an additive-latency holding stage. When that stage expires, the block emits a one-cycle internal issue pulse that carries the bank number. A second delay stage then places a read-data-valid window or a write-data-expected window on the output.

The read latency is the additive latency plus the CAS latency, and the write latency is one cycle less. A window lasts half the burst length in clock cycles, because data moves on both clock edges. The three settings are loaded by a mode strobe, and only while nothing is in flight. Each of four banks remembers when it was activated, so a column command that would reach the array before the activate-to-column delay has elapsed is reported on an error pulse. The surrounding model uses the windows to decide when to drive or capture data.

Top module: `pcas_timing`

## Requirements
- R1: The pins are sampled at each rising edge. Activate is csN=0, rasN=0, casN=1, weN=1. Read is csN=0, rasN=1, casN=0, weN=1. Write is csN=0, rasN=1, casN=0, weN=0. Every other pattern is a no-operation.
- R2: A column command sampled at edge E0 raises issueRd (read) or issueWr (write) for exactly one cycle: the cycle that begins at edge E_AL. issueBank carries the bank of that command during the pulse.
- R3: After a Read sampled at E0, rdValid is high from edge E_RL for B cycles, where RL = AL + CL and B is the burst duration in clocks.
- R4: After a Write sampled at E0, wrExpect is high from edge E_WL for B cycles, where WL = RL - 1.
- R5: With burst8In=0 the burst length is 4 and B = 2. With burst8In=1 the burst length is 8 and B = 4.
- R6: Two same-type commands sampled B edges apart produce one continuous window of 2B cycles, with no gap.
- R7: Several commands may be in flight at once. A Read followed one edge later by a Write has a read window and a write window that start in the same cycle.
- R8: A mode strobe that is accepted loads AL from alIn, CL from clIn and the burst size from burst8In at that edge. After reset the settings are AL=0, CL=3 and burst length 4.
- R9: A mode strobe is ignored, and modeRejected pulses in the following cycle, if any command is still in flight or a column command is sampled in the same cycle.
- R10: A mode strobe with AL above 4, CL below 3 or CL above 5 is ignored as a whole, and modeRejected pulses in the following cycle.
- R11: rcdErr pulses in the cycle after a column command whose bank has had fewer than TRCD edges since its Activate, with AL added to that count (TRCD = 3 by default).
- R12: A column command to a bank that has never been activated since reset also pulses rcdErr.
- R13: While csN is high, no pin pattern starts a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank of the command |
| modeSet | input | 1 | Load latency and burst settings |
| alIn | input | 3 | Additive latency to load (0 to 4) |
| clIn | input | 3 | CAS latency to load (3 to 5) |
| burst8In | input | 1 | 1 selects burst length 8, 0 selects 4 |
| issueRd | output | 1 | Internal read issue pulse |
| issueWr | output | 1 | Internal write issue pulse |
| issueBank | output | 2 | Bank of the issued command |
| rdValid | output | 1 | Read data window |
| wrExpect | output | 1 | Write data window |
| rcdErr | output | 1 | Column command arrived too early after Activate |
| modeRejected | output | 1 | Mode strobe was ignored |

## Verification
Because the write latency is one less than the read latency, a Write sampled one edge after a Read opens its window in the same cycle as the read window. The bench provokes this case and checks, cycle by cycle, that both windows are high together, with the right lengths and the right bank on each issue pulse. The second collision is a mode strobe that lands on the same edge as a column command. The bench checks that modeRejected pulses and that the read which follows still uses the latency that was in force before the strobe.

// File: rtl/pcas_pkg.sv
package pcas_pkg;
  localparam int AL_MAX      = 4;
  localparam int CL_MIN      = 3;
  localparam int CL_MAX      = 5;
  localparam int BANKS       = 4;
  localparam int BANK_W      = $clog2(BANKS);
  localparam int AL_W        = 3;
  localparam int CL_W        = 3;
  localparam int BEATS_SHORT = 2;
  localparam int BEATS_LONG  = 4;
  localparam int BEAT_W      = $clog2(BEATS_LONG + 1);

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR
  } cmdKind_t;

  typedef struct packed {
    logic              push;
    logic              isWrite;
    logic [BANK_W-1:0] bank;
  } colStrobe_t;

  typedef struct packed {
    logic [AL_W-1:0] al;
    logic [CL_W-1:0] cl;
    logic            burst8;
  } modeCfg_t;
endpackage

// File: rtl/pcas_burst.sv
module pcas_burst
  import pcas_pkg::*;
#(
  parameter int CNT_W = BEAT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             active
);
  logic [CNT_W-1:0] beatsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatsLeft <= '0;
    end else if (load) begin
      beatsLeft <= len;
    end else if (beatsLeft != '0) begin
      beatsLeft <= beatsLeft - CNT_W'(1);
    end
  end

  assign active = (beatsLeft != '0);

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatsLeft <= CNT_W'(BEATS_LONG));

  // R6
  load_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> active);
endmodule

// File: rtl/pcas_ctrl.sv
module pcas_ctrl
  import pcas_pkg::*;
#(
  parameter int TRCD = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic              modeSet,
  input  logic [AL_W-1:0]   alIn,
  input  logic [CL_W-1:0]   clIn,
  input  logic              burst8In,
  input  logic              pendingIn,
  output colStrobe_t        strobe,
  output modeCfg_t          cfg,
  output logic              rcdErr,
  output logic              modeRejected
);
  localparam int CNT_W = $clog2(TRCD + 1);
  localparam logic [CNT_W-1:0] RCD_SAT = CNT_W'(TRCD);
  localparam logic [AL_W-1:0]  AL_TOP  = AL_W'(AL_MAX);
  localparam logic [CL_W-1:0]  CL_LOW  = CL_W'(CL_MIN);
  localparam logic [CL_W-1:0]  CL_TOP  = CL_W'(CL_MAX);

  cmdKind_t         kind;
  logic             isCol;
  logic [BANKS-1:0] opened;
  logic [CNT_W-1:0] elapsed [BANKS];
  logic             tooEarly;
  logic             modeInRange;
  logic             modeAccept;

  // Command decode: all pins active low, sampled on the rising edge.
  always_comb begin
    kind = CMD_NOP;
    if (!csN) begin
      unique case ({rasN, casN, weN})
        3'b011:  kind = CMD_ACT;
        3'b101:  kind = CMD_RD;
        3'b100:  kind = CMD_WR;
        default: kind = CMD_NOP;
      endcase
    end
  end

  assign isCol = (kind == CMD_RD) || (kind == CMD_WR);

  always_comb begin
    strobe.push    = isCol;
    strobe.isWrite = (kind == CMD_WR);
    strobe.bank    = bankAddr;
  end

  // Per-bank activate tracking: count edges since Activate, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opened <= '0;
      for (int b = 0; b < BANKS; b++) elapsed[b] <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (kind == CMD_ACT && bankAddr == BANK_W'(b)) begin
          opened[b]  <= 1'b1;
          elapsed[b] <= CNT_W'(1);
        end else if (opened[b] && elapsed[b] != RCD_SAT) begin
          elapsed[b] <= elapsed[b] + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    tooEarly = 1'b0;
    if (isCol) begin
      if (!opened[bankAddr]) tooEarly = 1'b1;
      else if (int'(elapsed[bankAddr]) + int'(cfg.al) < TRCD) tooEarly = 1'b1;
    end
  end

  // Mode settings: loaded only when legal and nothing is in flight.
  assign modeInRange = (alIn <= AL_TOP) && (clIn >= CL_LOW) && (clIn <= CL_TOP);
  assign modeAccept  = modeSet && modeInRange && !pendingIn && !isCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.al       <= '0;
      cfg.cl       <= CL_LOW;
      cfg.burst8   <= 1'b0;
      rcdErr       <= 1'b0;
      modeRejected <= 1'b0;
    end else begin
      if (modeAccept) begin
        cfg.al     <= alIn;
        cfg.cl     <= clIn;
        cfg.burst8 <= burst8In;
      end
      rcdErr       <= tooEarly;
      modeRejected <= modeSet && !modeAccept;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingIn |=> $stable(cfg));

  // R9
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeRejected |-> $past(modeSet));

  // R11
  rcd_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcdErr |-> $past(strobe.push));

  // R10
  cfg_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.al <= AL_TOP) && (cfg.cl >= CL_LOW) && (cfg.cl <= CL_TOP));
endmodule

// File: rtl/pcas_datapath.sv
module pcas_datapath
  import pcas_pkg::*;
#(
  parameter int AL_LIMIT = AL_MAX,
  parameter int CL_LIMIT = CL_MAX
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStrobe_t        strobe,
  input  modeCfg_t          cfg,
  output logic              issueRd,
  output logic              issueWr,
  output logic [BANK_W-1:0] issueBank,
  output logic              rdValid,
  output logic              wrExpect,
  output logic              pending
);
  localparam int LINE_N = AL_LIMIT + 1;
  localparam int TAP_N  = CL_LIMIT;
  localparam int CH_N   = 2;

  colStrobe_t         alLine [LINE_N];
  colStrobe_t         picked;
  logic [TAP_N-1:0]   rdTaps, wrTaps;
  logic [TAP_N-2:0]   rdSr, wrSr;
  logic               rdLoad, wrLoad;
  logic [CH_N-1:0]    chLoad, chActive;
  logic [BEAT_W-1:0]  beats;
  logic               lineBusy;

  // Additive-latency holding line: entry k holds the command sampled k+1 edges ago.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LINE_N; k++) alLine[k] <= '0;
    end else begin
      alLine[0] <= strobe;
      for (int k = 1; k < LINE_N; k++) alLine[k] <= alLine[k-1];
    end
  end

  assign picked    = alLine[cfg.al];
  assign issueRd   = picked.push && !picked.isWrite;
  assign issueWr   = picked.push &&  picked.isWrite;
  assign issueBank = picked.bank;

  // CAS-latency taps: tap k is the issue pulse delayed by k cycles.
  assign rdTaps = {rdSr, issueRd};
  assign wrTaps = {wrSr, issueWr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSr <= '0;
      wrSr <= '0;
    end else begin
      rdSr <= rdTaps[TAP_N-2:0];
      wrSr <= wrTaps[TAP_N-2:0];
    end
  end

  // Window opens at edge AL+CL (read) or AL+CL-1 (write) after the command.
  assign rdLoad = rdTaps[cfg.cl - CL_W'(1)];
  assign wrLoad = wrTaps[cfg.cl - CL_W'(2)];
  assign beats  = cfg.burst8 ? BEAT_W'(BEATS_LONG) : BEAT_W'(BEATS_SHORT);
  assign chLoad = {wrLoad, rdLoad};

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    pcas_burst #(.CNT_W(BEAT_W)) burst_i (
      .clk    (clk),
      .rstN   (rstN),
      .load   (chLoad[ch]),
      .len    (beats),
      .active (chActive[ch])
    );
  end

  assign rdValid  = chActive[0];
  assign wrExpect = chActive[1];

  always_comb begin
    lineBusy = 1'b0;
    for (int k = 0; k < LINE_N; k++) lineBusy = lineBusy | alLine[k].push;
  end

  assign pending = lineBusy || (|rdSr) || (|wrSr) || (|chActive);

  // R3
  rd_load_leads_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(rdLoad));

  // R4
  wr_load_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLoad |=> wrExpect);

  // R2
  issue_from_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueRd || issueWr) |-> lineBusy);
endmodule

// File: rtl/pcas_timing.sv
module pcas_timing
  import pcas_pkg::*;
#(
  parameter int TRCD = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic              modeSet,
  input  logic [AL_W-1:0]   alIn,
  input  logic [CL_W-1:0]   clIn,
  input  logic              burst8In,
  output logic              issueRd,
  output logic              issueWr,
  output logic [BANK_W-1:0] issueBank,
  output logic              rdValid,
  output logic              wrExpect,
  output logic              rcdErr,
  output logic              modeRejected
);
  colStrobe_t strobe;
  modeCfg_t   cfg;
  logic       pending;

  pcas_ctrl #(.TRCD(TRCD)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .csN          (csN),
    .rasN         (rasN),
    .casN         (casN),
    .weN          (weN),
    .bankAddr     (bankAddr),
    .modeSet      (modeSet),
    .alIn         (alIn),
    .clIn         (clIn),
    .burst8In     (burst8In),
    .pendingIn    (pending),
    .strobe       (strobe),
    .cfg          (cfg),
    .rcdErr       (rcdErr),
    .modeRejected (modeRejected)
  );

  pcas_datapath #(.AL_LIMIT(AL_MAX), .CL_LIMIT(CL_MAX)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfg       (cfg),
    .issueRd   (issueRd),
    .issueWr   (issueWr),
    .issueBank (issueBank),
    .rdValid   (rdValid),
    .wrExpect  (wrExpect),
    .pending   (pending)
  );
endmodule

// File: tb/pcas_timing_tb.sv
`timescale 1ns/1ps
module pcas_timing_tb_top;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankAddr = '0;
  logic modeSet = 1'b0;
  logic [2:0] alIn = '0, clIn = 3'd3;
  logic burst8In = 1'b0;
  logic issueRd, issueWr, rdValid, wrExpect, rcdErr, modeRejected;
  logic [1:0] issueBank;

  int nChecks = 0, nFail = 0;
  int mAl = 0, mCl = 3;
  bit mB8 = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcas_timing dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .modeSet(modeSet), .alIn(alIn), .clIn(clIn),
    .burst8In(burst8In), .issueRd(issueRd), .issueWr(issueWr),
    .issueBank(issueBank), .rdValid(rdValid), .wrExpect(wrExpect),
    .rcdErr(rcdErr), .modeRejected(modeRejected)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int code, input logic [1:0] bank);
    bankAddr = bank;
    csN = (code == NOP);
    case (code)
      ACT:     {rasN, casN, weN} = 3'b011;
      RD:      {rasN, casN, weN} = 3'b101;
      WR:      {rasN, casN, weN} = 3'b100;
      default: {rasN, casN, weN} = 3'b111;
    endcase
  endtask

  function automatic bit inWin(input int k, input int c, input int lat, input int len);
    return (k >= c + lat) && (k < c + lat + len);
  endfunction

  task automatic idle(input int n);
    drive(NOP, 2'd0);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setMode(input int al, input int cl, input bit b8,
                         input bit expRej, input string req);
    alIn = 3'(al); clIn = 3'(cl); burst8In = b8; modeSet = 1'b1;
    tick();
    modeSet = 1'b0;
    chk(modeRejected == expRej, req, "modeRejected", modeRejected, expRej);
    if (!expRej) begin mAl = al; mCl = cl; mB8 = b8; end
  endtask

  // One or two column commands; every cycle compared with the model.
  task automatic playPair(input string req, input bit w1, input logic [1:0] b1,
                          input bit use2, input int gap, input bit w2,
                          input logic [1:0] b2);
    int rl, wl, bl, last;
    bit expRd, expWr, expIr, expIw;
    logic [1:0] expBank;
    rl = mAl + mCl; wl = rl - 1; bl = mB8 ? 4 : 2;
    last = rl + bl + gap + 4;
    drive(w1 ? WR : RD, b1);
    for (int k = 0; k <= last; k++) begin
      tick();
      expRd = (!w1 && inWin(k, 0, rl, bl)) || (use2 && !w2 && inWin(k, gap, rl, bl));
      expWr = ( w1 && inWin(k, 0, wl, bl)) || (use2 &&  w2 && inWin(k, gap, wl, bl));
      expIr = (!w1 && k == mAl) || (use2 && !w2 && k == gap + mAl);
      expIw = ( w1 && k == mAl) || (use2 &&  w2 && k == gap + mAl);
      expBank = (use2 && k == gap + mAl) ? b2 : b1;
      chk(rdValid == expRd, req, $sformatf("rdValid k=%0d", k), rdValid, expRd);
      chk(wrExpect == expWr, req, $sformatf("wrExpect k=%0d", k), wrExpect, expWr);
      chk(issueRd == expIr, "R2", $sformatf("issueRd k=%0d", k), issueRd, expIr);
      chk(issueWr == expIw, "R2", $sformatf("issueWr k=%0d", k), issueWr, expIw);
      if (expIr || expIw)
        chk(issueBank == expBank, "R2", "issueBank", issueBank, expBank);
      if (use2 && k == gap - 1) drive(w2 ? WR : RD, b2);
      else drive(NOP, 2'd0);
    end
  endtask

  task automatic testReset();
    chk(!rdValid && !wrExpect && !issueRd && !issueWr, "R8", "outputs idle after reset",
        {rdValid, wrExpect, issueRd, issueWr}, 0);
    chk(!rcdErr && !modeRejected, "R8", "flags idle after reset", {rcdErr, modeRejected}, 0);
  endtask

  task automatic testUnopenedBank();
    drive(RD, 2'd3);
    tick();
    drive(NOP, 2'd0);
    chk(rcdErr == 1'b1, "R12", "rcdErr for never-activated bank", rcdErr, 1);
    idle(12);
  endtask

  task automatic openAllBanks();
    for (int b = 0; b < 4; b++) begin drive(ACT, 2'(b)); tick(); end
    idle(4);
  endtask

  task automatic testChipSelect();
    bit seen = 0;
    bankAddr = 2'd0; csN = 1'b1; {rasN, casN, weN} = 3'b101;
    tick();
    {rasN, casN, weN} = 3'b100;
    tick();
    drive(NOP, 2'd0);
    for (int k = 0; k < 14; k++) begin
      if (rdValid || wrExpect || issueRd || issueWr) seen = 1;
      tick();
    end
    chk(!seen, "R13", "no activity with csN high", seen, 0);
  endtask

  task automatic testBusyModeSet();
    drive(RD, 2'd0);
    tick();
    drive(NOP, 2'd0);
    alIn = 3'd0; clIn = 3'd5; burst8In = 1'b1; modeSet = 1'b1;
    tick();
    modeSet = 1'b0;
    chk(modeRejected == 1'b1, "R9", "reject while in flight", modeRejected, 1);
    idle(16);
    alIn = 3'd0; clIn = 3'd5; modeSet = 1'b1;
    drive(RD, 2'd1);
    tick();
    modeSet = 1'b0;
    drive(NOP, 2'd0);
    chk(modeRejected == 1'b1, "R9", "reject with column in same cycle", modeRejected, 1);
    idle(16);
    playPair("R9", 1'b0, 2'd1, 1'b0, 1, 1'b0, 2'd0);
  endtask

  task automatic testRcd();
    setMode(0, 3, 0, 0, "R8");
    drive(ACT, 2'd1); tick();
    drive(RD, 2'd1);  tick();
    drive(NOP, 2'd0);
    chk(rcdErr == 1'b1, "R11", "read one edge after activate, AL=0", rcdErr, 1);
    idle(12);
    drive(ACT, 2'd0); tick();
    drive(NOP, 2'd0); tick(); tick();
    drive(WR, 2'd0);  tick();
    drive(NOP, 2'd0);
    chk(rcdErr == 1'b0, "R11", "write three edges after activate", rcdErr, 0);
    idle(12);
    setMode(2, 3, 0, 0, "R8");
    drive(ACT, 2'd2); tick();
    drive(RD, 2'd2);  tick();
    drive(NOP, 2'd0);
    chk(rcdErr == 1'b0, "R11", "early read covered by AL=2", rcdErr, 0);
    idle(14);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnopenedBank();
    openAllBanks();
    // R8 defaults: AL=0 CL=3 BL4, so RL=3
    playPair("R3", 1'b0, 2'd0, 1'b0, 1, 1'b0, 2'd0);
    setMode(2, 3, 0, 0, "R8");
    playPair("R3", 1'b0, 2'd2, 1'b0, 1, 1'b0, 2'd0);
    playPair("R4", 1'b1, 2'd3, 1'b0, 1, 1'b0, 2'd0);
    setMode(0, 3, 1, 0, "R8");
    playPair("R5", 1'b0, 2'd1, 1'b0, 1, 1'b0, 2'd0);
    playPair("R5", 1'b1, 2'd1, 1'b0, 1, 1'b0, 2'd0);
    playPair("R6", 1'b0, 2'd0, 1'b1, 4, 1'b0, 2'd3);
    setMode(1, 4, 0, 0, "R8");
    playPair("R6", 1'b1, 2'd2, 1'b1, 2, 1'b1, 2'd1);
    setMode(2, 3, 0, 0, "R8");
    playPair("R7", 1'b0, 2'd1, 1'b1, 1, 1'b1, 2'd2);
    testChipSelect();
    testBusyModeSet();
    setMode(5, 3, 0, 1, "R10");
    setMode(0, 6, 0, 1, "R10");
    setMode(0, 2, 1, 1, "R10");
    playPair("R10", 1'b0, 2'd0, 1'b0, 1, 1'b0, 2'd0);
    testRcd();
    setMode(4, 5, 1, 0, "R8");
    playPair("R3", 1'b0, 2'd3, 1'b0, 1, 1'b0, 2'd0);
    playPair("R1", 1'b1, 2'd0, 1'b0, 1, 1'b0, 2'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule